// File: doc/BRIEF.md
# Power Management Event and Timer Register Block

This block holds the fixed power-management hardware of a legacy system: a free-running timer, a small set of sticky event status flags with matching enables, a control word, and a level interrupt that is raised while any enabled event is pending. Software reaches it through a 64-byte I/O window. The status, enable and control words are accessed 16 bits at a time. The timer is read as one 32-bit word. A separate one-byte command port turns the interrupt-routing mode bit on and off with two code values.

The timer advances by one on each cycle where the `tick` strobe is high. The platform drives this strobe at the nominal 3.579545 MHz rate, derived from the block clock. The overflow flag does not follow a rollover of the visible bits. It follows a stored overflow point that always sits on a multiple of 2^STEP_LOG2, with a default of 2^23. When software clears the flag, the overflow point moves forward to the next such boundary above the current count. A soft-off command written to the control word produces a one-cycle shutdown request. Every pin is a plain level or strobe. No handshake is involved: reads are combinational, and writes take effect at the clock edge where `acc_wr` is sampled high.

Top module: `pm_fixed_regs`

## Requirements
- R1: After reset, the status, enable and control words read 0, the timer reads 0, `sci` and `off_req` are low, and the first overflow point is 2^STEP_LOG2.
- R2: Only the low 6 address bits are decoded. A 16-bit access (`acc_wide`=0) reaches status at 0x00, enable at 0x02 and control at 0x04. A 32-bit access (`acc_wide`=1) at 0x08 reads the timer. Every other offset or width reads 0, and writes to it change nothing. 32-bit writes are always ignored.
- R3: The timer increments by one on each clock where `tick` is high. A read returns its low RD_W bits (24 by default), zero-extended to 32 bits.
- R4: An event strobe sets its sticky status bit at the next clock edge: RTC at bit 10, power button at bit 8, global at bit 5.
- R5: A status write clears each bit written as 1 and leaves bits written as 0 unchanged. An event strobe in the same cycle as a clear of its bit wins, and the bit stays set.
- R6: Status bit 0 (timer overflow) becomes set one clock after the count is at or beyond the overflow point. Clearing it while it is set moves the point to (count + 2^STEP_LOG2) rounded down to a multiple of 2^STEP_LOG2. Writing 1 to bit 0 while it is clear leaves the point unchanged.
- R7: `sci` is high exactly while some bit among 10, 8, 5 and 0 is set in both status and enable. Enable bits outside that set have no effect on it.
- R8: Control bit 13 is never stored and reads 0. A control write with bit 13 set and bits 11:10 equal to 0 pulses `off_req` high for exactly one cycle, starting at the next edge. Any other control write does not pulse it.
- R9: On the command port, 0xF1 sets control bit 0 and 0xF0 clears it. Any other value has no effect. When a control write and a command fall in the same cycle, the command is applied on top of the written value.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timer advance strobe |
| ev_rtc | input | 1 | RTC event strobe |
| ev_pwr | input | 1 | Power button event strobe |
| ev_gbl | input | 1 | Global event strobe |
| acc_addr | input | ADDR_W | I/O address; only bits 5:0 are decoded |
| acc_wide | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| acc_wr | input | 1 | Write strobe |
| acc_wdata | input | 16 | Write data |
| acc_rdata | output | 32 | Combinational read data for acc_addr/acc_wide |
| smi_wr | input | 1 | Command port write strobe |
| smi_data | input | 8 | Command port byte |
| sci | output | 1 | Level interrupt |
| off_req | output | 1 | One-cycle soft power-off request |

## Verification
The assertions assume that event, tick and command strobes are synchronous to `clk`. They also assume that a status clear and an overflow of the count do not coincide with a wrap of the full CNT_W-bit counter. The stimulus drives every input on the falling edge and keeps the count far below the counter's wrap. The bench uses a small step (2^4) and a narrow read width, so the overflow-point and truncation rules can be swept over several periods.

// File: rtl/pm_regs_pkg.sv
`timescale 1ns/1ps
package pm_regs_pkg;
  localparam int unsigned OFF_W = 6;
  localparam logic [OFF_W-1:0] OFF_STS = 6'h00;
  localparam logic [OFF_W-1:0] OFF_EN  = 6'h02;
  localparam logic [OFF_W-1:0] OFF_CTL = 6'h04;
  localparam logic [OFF_W-1:0] OFF_TMR = 6'h08;

  localparam int unsigned BIT_TMR = 0;
  localparam int unsigned BIT_GBL = 5;
  localparam int unsigned BIT_PWR = 8;
  localparam int unsigned BIT_RTC = 10;
  localparam int unsigned N_EV    = 3;

  localparam int unsigned CTL_MODE = 0;
  localparam int unsigned CTL_SUSP = 13;
  localparam int unsigned CTL_TYP_LO = 10;

  localparam logic [7:0] CMD_ON  = 8'hF1;
  localparam logic [7:0] CMD_OFF = 8'hF0;

  localparam logic [15:0] SRC_MASK = 16'h0521;

  // status position of strobed event i (0 = rtc, 1 = power button, 2 = global)
  function automatic int unsigned ev_pos(input int unsigned i);
    case (i)
      0:       ev_pos = BIT_RTC;
      1:       ev_pos = BIT_PWR;
      default: ev_pos = BIT_GBL;
    endcase
  endfunction
endpackage

// File: rtl/pm_timer.sv
`timescale 1ns/1ps
module pm_timer #(
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned STEP_LOG2 = 23
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             move_pt,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] pt,
  output logic             hit
);
  localparam logic [CNT_W-1:0] STEP   = CNT_W'(1) << STEP_LOG2;
  localparam logic [CNT_W-1:0] LOW_MK = STEP - CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, pt_q, pt_nxt;

  assign pt_nxt = (cnt_q + STEP) & ~LOW_MK;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pt_q  <= STEP;
    end else begin
      if (tick)    cnt_q <= cnt_q + CNT_W'(1);
      if (move_pt) pt_q  <= pt_nxt;
    end
  end

  assign cnt = cnt_q;
  assign pt  = pt_q;
  assign hit = (cnt_q >= pt_q);
endmodule

// File: rtl/pm_status.sv
`timescale 1ns/1ps
module pm_status
  import pm_regs_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [N_EV-1:0] ev,
  input  logic        tmr_hit,
  input  logic        wr,
  input  logic [15:0] wdata,
  output logic        move_pt,
  output logic [15:0] sts
);
  logic [N_EV-1:0] ev_q;
  logic            tmr_q;

  for (genvar g = 0; g < N_EV; g++) begin : g_ev
    localparam int unsigned POS = ev_pos(g);
    logic clr;
    assign clr = wr && wdata[POS];
    always_ff @(posedge clk) begin
      if (!rst_n)      ev_q[g] <= 1'b0;
      else if (ev[g])  ev_q[g] <= 1'b1;
      else if (clr)    ev_q[g] <= 1'b0;
    end
  end

  logic tmr_clr;
  assign tmr_clr = wr && wdata[BIT_TMR];
  assign move_pt = tmr_clr && tmr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       tmr_q <= 1'b0;
    else if (tmr_clr) tmr_q <= 1'b0;
    else if (tmr_hit) tmr_q <= 1'b1;
  end

  always_comb begin
    sts = '0;
    sts[BIT_TMR] = tmr_q;
    for (int i = 0; i < N_EV; i++) sts[ev_pos(i)] = ev_q[i];
  end
endmodule

// File: rtl/pm_ctrl.sv
`timescale 1ns/1ps
module pm_ctrl
  import pm_regs_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_ctl,
  input  logic [15:0] wdata,
  input  logic        smi_wr,
  input  logic [7:0]  smi_data,
  output logic [15:0] en,
  output logic [15:0] ctl,
  output logic        off_req
);
  logic [15:0] en_q, ctl_q, ctl_base, ctl_nxt;
  logic        off_q;

  always_comb begin
    ctl_base = ctl_q;
    if (wr_ctl) begin
      ctl_base = wdata;
      ctl_base[CTL_SUSP] = 1'b0;
    end
    ctl_nxt = ctl_base;
    if (smi_wr && smi_data == CMD_ON)  ctl_nxt[CTL_MODE] = 1'b1;
    if (smi_wr && smi_data == CMD_OFF) ctl_nxt[CTL_MODE] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= '0;
      ctl_q <= '0;
      off_q <= 1'b0;
    end else begin
      if (wr_en) en_q <= wdata;
      ctl_q <= ctl_nxt;
      off_q <= wr_ctl && wdata[CTL_SUSP] && (wdata[CTL_TYP_LO+1:CTL_TYP_LO] == 2'b00);
    end
  end

  assign en      = en_q;
  assign ctl     = ctl_q;
  assign off_req = off_q;
endmodule

// File: rtl/pm_fixed_regs.sv
`timescale 1ns/1ps
module pm_fixed_regs
  import pm_regs_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned STEP_LOG2 = 23,
  parameter int unsigned RD_W      = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              ev_rtc,
  input  logic              ev_pwr,
  input  logic              ev_gbl,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_wide,
  input  logic              acc_wr,
  input  logic [15:0]       acc_wdata,
  output logic [31:0]       acc_rdata,
  input  logic              smi_wr,
  input  logic [7:0]        smi_data,
  output logic              sci,
  output logic              off_req
);
  localparam int unsigned PAD_W = 32 - RD_W;

  logic [OFF_W-1:0] off;
  logic             wr16, wr_sts, wr_en, wr_ctl, move_pt, hit;
  logic [CNT_W-1:0] cnt, pt;
  logic [15:0]      sts, en, ctl;
  logic             unused_addr;

  assign off         = acc_addr[OFF_W-1:0];
  assign unused_addr = ^acc_addr[ADDR_W-1:OFF_W];
  assign wr16   = acc_wr && !acc_wide;
  assign wr_sts = wr16 && off == OFF_STS;
  assign wr_en  = wr16 && off == OFF_EN;
  assign wr_ctl = wr16 && off == OFF_CTL;

  pm_timer #(.CNT_W(CNT_W), .STEP_LOG2(STEP_LOG2)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .move_pt(move_pt),
    .cnt(cnt), .pt(pt), .hit(hit)
  );

  pm_status u_status (
    .clk(clk), .rst_n(rst_n), .ev({ev_gbl, ev_pwr, ev_rtc}), .tmr_hit(hit),
    .wr(wr_sts), .wdata(acc_wdata), .move_pt(move_pt), .sts(sts)
  );

  pm_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ctl(wr_ctl), .wdata(acc_wdata),
    .smi_wr(smi_wr), .smi_data(smi_data), .en(en), .ctl(ctl), .off_req(off_req)
  );

  assign sci = |(sts & en & SRC_MASK);

  always_comb begin
    acc_rdata = '0;
    if (!acc_wide) begin
      case (off)
        OFF_STS: acc_rdata = {16'h0, sts};
        OFF_EN:  acc_rdata = {16'h0, en};
        OFF_CTL: acc_rdata = {16'h0, ctl};
        default: acc_rdata = '0;
      endcase
    end else if (off == OFF_TMR) begin
      acc_rdata = {{PAD_W{1'b0}}, cnt[RD_W-1:0]};
    end
  end
endmodule

// File: rtl/pm_fixed_regs_chk.sv
`timescale 1ns/1ps
module pm_fixed_regs_chk
  import pm_regs_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned CNT_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              ev_rtc,
  input logic              ev_pwr,
  input logic              ev_gbl,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              acc_wide,
  input logic              acc_wr,
  input logic [15:0]       acc_wdata,
  input logic              smi_wr,
  input logic [7:0]        smi_data,
  input logic [15:0]       sts,
  input logic [15:0]       ctl,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  pt,
  input logic              sci,
  input logic              off_req
);
  logic ctl_wr;
  assign ctl_wr = acc_wr && !acc_wide && acc_addr[OFF_W-1:0] == OFF_CTL;

  p_tick_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> cnt == $past(cnt) + CNT_W'(1));
  p_tick_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));
  p_rtc_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rtc |=> sts[BIT_RTC]);
  p_pwr_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pwr |=> sts[BIT_PWR]);
  p_gbl_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_gbl |=> sts[BIT_GBL]);
  p_ovf_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts[BIT_TMR]) |-> $past(cnt >= pt));
  p_pt_aligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(pt) |-> pt > $past(cnt));
  p_sci_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sci |-> (sts & SRC_MASK) != 16'h0);
  p_off_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    off_req |=> !off_req);
  p_off_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    off_req |-> $past(ctl_wr && acc_wdata[CTL_SUSP] && acc_wdata[11:10] == 2'b00));
  p_susp_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl[CTL_SUSP]);
  p_cmd_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
    smi_wr && smi_data == CMD_ON |=> ctl[CTL_MODE]);
  p_cmd_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    smi_wr && smi_data == CMD_OFF |=> !ctl[CTL_MODE]);
endmodule

bind pm_fixed_regs pm_fixed_regs_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .ev_rtc(ev_rtc), .ev_pwr(ev_pwr),
  .ev_gbl(ev_gbl), .acc_addr(acc_addr), .acc_wide(acc_wide), .acc_wr(acc_wr),
  .acc_wdata(acc_wdata), .smi_wr(smi_wr), .smi_data(smi_data), .sts(sts),
  .ctl(ctl), .cnt(cnt), .pt(pt), .sci(sci), .off_req(off_req)
);

// File: tb/pm_fixed_regs_bench.sv
`timescale 1ns/1ps
module pm_fixed_regs_bench;
  localparam int unsigned AW = 16, CW = 12, SL = 4, RW = 5;
  localparam int unsigned STEP = 1 << SL;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 0, ev_rtc = 0, ev_pwr = 0, ev_gbl = 0;
  logic [AW-1:0] acc_addr = '0;
  logic acc_wide = 0, acc_wr = 0, smi_wr = 0;
  logic [15:0] acc_wdata = '0;
  logic [7:0] smi_data = '0;
  logic [31:0] acc_rdata;
  logic sci, off_req;

  int checks = 0, errors = 0, off_cnt = 0;
  int cnt_m = 0, pt_m = STEP;
  logic sts0_m = 0;

  always #5 clk = ~clk;

  pm_fixed_regs #(.ADDR_W(AW), .CNT_W(CW), .STEP_LOG2(SL), .RD_W(RW)) u_pm_fixed_regs (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ev_rtc(ev_rtc), .ev_pwr(ev_pwr),
    .ev_gbl(ev_gbl), .acc_addr(acc_addr), .acc_wide(acc_wide), .acc_wr(acc_wr),
    .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .smi_wr(smi_wr),
    .smi_data(smi_data), .sci(sci), .off_req(off_req)
  );

  always @(posedge clk) if (rst_n && off_req) off_cnt <= off_cnt + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr16(input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk);
    acc_addr = a; acc_wide = 0; acc_wdata = d; acc_wr = 1;
    @(negedge clk);
    acc_wr = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic w, output logic [31:0] d);
    acc_addr = a; acc_wide = w;
    #1 d = acc_rdata;
  endtask

  task automatic do_tick();
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
    cnt_m++;
    @(negedge clk);
    if (cnt_m >= pt_m) sts0_m = 1;
  endtask

  task automatic smi(input logic [7:0] v);
    @(negedge clk); smi_wr = 1; smi_data = v;
    @(negedge clk); smi_wr = 0;
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int oc;
    idle(3); rst_n = 1; idle(1);
    // R1 reset state
    rd(6'h00, 0, d); chk("R1 status", d, 0);
    rd(6'h02, 0, d); chk("R1 enable", d, 0);
    rd(6'h04, 0, d); chk("R1 control", d, 0);
    rd(6'h08, 1, d); chk("R1 timer", d, 0);
    chk("R1 sci", sci, 0); chk("R1 off_req", off_req, 0);

    // R4 R5 R7: exhaustive event set x enable sweep
    for (int s = 0; s < 8; s++) begin
      for (int e = 0; e < 16; e++) begin
        logic [15:0] en_v, st_v;
        en_v = {5'b0, e[3], 1'b0, e[2], 2'b0, e[1], 4'b0, e[0]} | 16'hF0DE;
        st_v = {5'b0, s[0], 1'b0, s[1], 2'b0, s[2], 5'b0};
        wr16(6'h00, 16'hFFFF);
        wr16(6'h02, en_v);
        @(negedge clk); ev_rtc = s[0]; ev_pwr = s[1]; ev_gbl = s[2];
        @(negedge clk); ev_rtc = 0; ev_pwr = 0; ev_gbl = 0;
        rd(6'h00, 0, d); chk("R4 sticky status", d, {16'h0, st_v});
        chk("R7 sci level", sci, |(st_v & en_v & 16'h0521));
      end
    end
    // R5 partial clear and event-wins
    wr16(6'h02, 16'h0000);
    @(negedge clk); ev_rtc = 1; ev_pwr = 1; ev_gbl = 1;
    @(negedge clk); ev_rtc = 0; ev_pwr = 0; ev_gbl = 0;
    wr16(6'h00, 16'h0100);
    rd(6'h00, 0, d); chk("R5 clear one bit", d, 32'h0420);
    @(negedge clk); acc_addr = 0; acc_wdata = 16'h0400; acc_wr = 1; ev_rtc = 1;
    @(negedge clk); acc_wr = 0; ev_rtc = 0;
    rd(6'h00, 0, d); chk("R5 set beats clear", d, 32'h0420);
    wr16(6'h00, 16'hFFFF);

    // R2 decode
    wr16(16'hAB42, 16'h1234);
    rd(6'h02, 0, d); chk("R2 alias write", d, 32'h1234);
    wr16(6'h06, 16'hFFFF);
    @(negedge clk); acc_addr = 6'h02; acc_wide = 1; acc_wdata = 16'h5555; acc_wr = 1;
    @(negedge clk); acc_wr = 0;
    rd(6'h02, 0, d); chk("R2 ignored writes enable", d, 32'h1234);
    rd(6'h04, 0, d); chk("R2 ignored writes control", d, 0);
    rd(6'h06, 0, d); chk("R2 unmapped read", d, 0);
    rd(6'h08, 0, d); chk("R2 narrow timer read", d, 0);
    rd(6'h00, 1, d); chk("R2 wide status read", d, 0);
    wr16(6'h02, 16'h0000);

    // R3 R6: timer sweep across several overflow periods
    for (int i = 0; i < 70; i++) begin
      do_tick();
      rd(6'h08, 1, d); chk("R3 timer value", d, cnt_m % (1 << RW));
      rd(6'h00, 0, d); chk("R6 overflow flag", d[0], sts0_m);
      if (i % 3 == 0) begin
        wr16(6'h00, 16'h0001);
        if (sts0_m) begin
          pt_m = (cnt_m + STEP) & ~(STEP - 1);
          sts0_m = 0;
        end
        idle(1);
        rd(6'h00, 0, d); chk("R6 after clear", d[0], sts0_m);
      end
    end
    // R7 timer source drives sci
    while (!sts0_m) do_tick();
    wr16(6'h02, 16'h0001);
    chk("R7 timer sci", sci, 1);
    wr16(6'h02, 16'h0000);
    chk("R7 sci drop", sci, 0);

    // R8 control
    oc = off_cnt;
    wr16(6'h04, 16'h3FFF); idle(2);
    rd(6'h04, 0, d); chk("R8 bit13 not stored", d, 32'h1FFF);
    chk("R8 no pulse typ3", off_cnt, oc);
    wr16(6'h04, 16'h2400); idle(2);
    chk("R8 no pulse typ1", off_cnt, oc);
    wr16(6'h04, 16'h2000); idle(2);
    chk("R8 soft-off pulse", off_cnt, oc + 1);
    rd(6'h04, 0, d); chk("R8 readback", d, 0);

    // R9 command port
    smi(8'hF1); rd(6'h04, 0, d); chk("R9 on", d, 1);
    smi(8'h55); rd(6'h04, 0, d); chk("R9 other ignored", d, 1);
    smi(8'hF2); rd(6'h04, 0, d); chk("R9 near code ignored", d, 1);
    smi(8'hF0); rd(6'h04, 0, d); chk("R9 off", d, 0);
    @(negedge clk); acc_addr = 6'h04; acc_wide = 0; acc_wdata = 16'h0100; acc_wr = 1;
    smi_wr = 1; smi_data = 8'hF1;
    @(negedge clk); acc_wr = 0; smi_wr = 0;
    rd(6'h04, 0, d); chk("R9 command over write", d, 32'h0101);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule